// File: doc/BRIEF.md
# Exception-Return Frame Unstacking Engine

This block performs the memory half of an exception return on a small microcontroller-class core. When the pipeline retires an exception-return branch, it hands the block the return code, its current security state and the stack pointers it keeps banked. The block works out which stack holds the saved frame. It captures that stack pointer into a private frame pointer, so the live stack pointer does not move while the frame is read. It then fetches the eight-word basic frame through a single-outstanding read port.

When the last word arrives, the block raises a one-cycle completion pulse. In that cycle the restored general registers, a cleaned return address and a status word with its bookkeeping bit removed are all valid. In the same cycle the block writes the popped stack pointer back to the bank it was taken from. If the saved status word records that a padding word was pushed on entry, that padding is removed from the written-back pointer.

Top module: `xret_unstack`

## Requirements
- R1: When the target security state equals `cur_secure`, the frame pointer is `cur_sp` and the write-back bank code is 0 (active pointer).
- R2: When the target security state differs from `cur_secure`, the frame pointer is `oth_psp` (bank code 2) if the return is to thread mode and `ret_code` bit 2 is 1. Otherwise it is `oth_msp` (bank code 1). A return is to handler mode exactly when `ret_code[3:0]` equals 4'h1.
- R3: The target state is secure only when the parameter `HAS_SEC` is 1 and `ret_code` bit 6 is 1.
- R4: After an accepted start the block issues exactly eight reads at frame pointer + 0, 4, 8, ... 28, in that order. `rd_req` stays high and `rd_addr` stays fixed until `rd_ack`, and only one read is outstanding at a time.
- R5: The word returned for offset 4k is delivered on the k-th restored output, in the order `out_r0`, `out_r1`, `out_r2`, `out_r3`, `out_r12`, `out_lr`, `out_pc`, `out_xpsr`.
- R6: `out_pc` is the word at offset 0x18 with bit 0 forced to 0. `pc_warn` is 1 exactly when that word's bit 0 was 1.
- R7: In the `done` cycle `sp_wr_en` is 1, `sp_wr_bank` carries the bank from R1/R2, and `sp_wr_val` is frame pointer + 0x20 (frame pointer 8-byte aligned). `sp_wr_en` is 0 in every other cycle.
- R8: If bit 9 of the word at offset 0x1C is 1, bit 2 of `sp_wr_val` is set to 1.
- R9: `out_xpsr` is the word at offset 0x1C with bit 9 cleared.
- R10: `start` is ignored unless the block is idle. `done` lasts exactly one cycle and comes on the cycle after the eighth `rd_ack`.
- R11: A synchronous active-high `rst` returns the block to idle, aborting any read sequence. On the next cycle `done`, `rd_req`, `sp_wr_en` and `pc_warn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exception return (taken only when idle) |
| ret_code | input | 32 | Exception-return code |
| cur_secure | input | 1 | Current security state |
| cur_sp | input | 32 | Active stack pointer |
| oth_msp | input | 32 | Main stack pointer of the other security state |
| oth_psp | input | 32 | Process stack pointer of the other security state |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| out_r0 | output | 32 | Restored R0 |
| out_r1 | output | 32 | Restored R1 |
| out_r2 | output | 32 | Restored R2 |
| out_r3 | output | 32 | Restored R3 |
| out_r12 | output | 32 | Restored R12 |
| out_lr | output | 32 | Restored link register |
| out_pc | output | 32 | Restored return address, bit 0 cleared |
| out_xpsr | output | 32 | Restored status word, bit 9 cleared |
| pc_warn | output | 1 | Saved return address had bit 0 set |
| sp_wr_en | output | 1 | Stack pointer write-back strobe |
| sp_wr_bank | output | 2 | Write-back bank: 0 active, 1 other main, 2 other process |
| sp_wr_val | output | 32 | Stack pointer value written back |

## Verification
The assertions assume the memory side raises `rd_ack` only while `rd_req` is high. They also assume `rst` is asserted at time zero. The step check on `rd_addr` assumes a frame that does not wrap the 32-bit address space. The bench's memory model acknowledges only an outstanding request, with 0 to 3 wait cycles. It places every frame well inside the address range and at 8-byte aligned pointers. Start pulses sent during a sequence test only the ignore rule, and reset is driven at the clock's inactive edge.

// File: rtl/xret_pkg.sv
package xret_pkg;
  localparam int WORD_W      = 32;
  localparam int FRAME_WORDS = 8;
  localparam int IDX_W       = $clog2(FRAME_WORDS);
  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam int REALIGN_BIT = 9;
  localparam int SLOT_PC     = 6;
  localparam int SLOT_PSR    = 7;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    BANK_ACTIVE     = 2'd0,
    BANK_OTHER_MAIN = 2'd1,
    BANK_OTHER_PROC = 2'd2
  } bank_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DONE = 2'd2
  } seq_e;

  // Byte address of frame slot idx.
  function automatic word_t slot_addr(word_t base, logic [IDX_W-1:0] idx);
    return base + (word_t'(idx) << 2);
  endfunction

  // Stack pointer after the pop, with padding removed when flagged.
  function automatic word_t sp_after(word_t base, logic realign);
    word_t s;
    s = base + word_t'(FRAME_BYTES);
    if (realign) s[2] = 1'b1;
    return s;
  endfunction

  function automatic word_t clean_pc(word_t w);
    word_t r;
    r = w;
    r[0] = 1'b0;
    return r;
  endfunction

  function automatic word_t strip_psr(word_t w);
    word_t r;
    r = w;
    r[REALIGN_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/xret_stack_select.sv
module xret_stack_select
  import xret_pkg::*;
#(
  parameter bit          HAS_SEC      = 1'b1,
  parameter int          SEL_BIT      = 2,
  parameter int          SEC_BIT      = 6,
  parameter logic [3:0]  HANDLER_CODE = 4'h1
) (
  input  word_t ret_code,
  input  logic  cur_secure,
  input  word_t cur_sp,
  input  word_t oth_msp,
  input  word_t oth_psp,
  output bank_e bank,
  output word_t frame_base,
  output logic  to_handler,
  output logic  to_secure
);
  logic want_proc;

  generate
    if (HAS_SEC) begin : g_sec
      assign to_secure = ret_code[SEC_BIT];
    end else begin : g_nosec
      assign to_secure = 1'b0;
    end
  endgenerate

  assign to_handler = (ret_code[3:0] == HANDLER_CODE);
  assign want_proc  = !to_handler && ret_code[SEL_BIT];

  always_comb begin
    if (to_secure == cur_secure) begin
      bank       = BANK_ACTIVE;
      frame_base = cur_sp;
    end else if (want_proc) begin
      bank       = BANK_OTHER_PROC;
      frame_base = oth_psp;
    end else begin
      bank       = BANK_OTHER_MAIN;
      frame_base = oth_msp;
    end
  end
endmodule

// File: rtl/xret_read_seq.sv
module xret_read_seq
  import xret_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  word_t                       frame_base,
  input  bank_e                       bank_in,
  output logic                        rd_req,
  output word_t                       rd_addr,
  input  logic                        rd_ack,
  input  word_t                       rd_data,
  output logic                        done,
  output word_t                       base_q,
  output bank_e                       bank_q,
  output word_t [FRAME_WORDS-1:0]     words,
  output logic                        ev_accept,
  output logic                        ev_capture,
  output logic                        ev_last
);
  seq_e             st;
  logic [IDX_W-1:0] idx;

  assign ev_accept  = (st == ST_IDLE) && start;
  assign ev_capture = (st == ST_READ) && rd_ack;
  assign ev_last    = (idx == IDX_W'(FRAME_WORDS - 1));
  assign rd_req     = (st == ST_READ);
  assign rd_addr    = slot_addr(base_q, idx);
  assign done       = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      idx    <= '0;
      base_q <= '0;
      bank_q <= BANK_ACTIVE;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_READ;
          idx    <= '0;
          base_q <= frame_base;
          bank_q <= bank_in;
        end
        ST_READ: if (rd_ack) begin
          if (ev_last) st <= ST_DONE;
          else         idx <= idx + 1'b1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || ev_accept)                          words[g] <= '0;
      else if (ev_capture && idx == IDX_W'(g))       words[g] <= rd_data;
    end
  end

  // R4: request and address held until acknowledged
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R4: consecutive reads step by one word
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    (ev_capture && !ev_last) |=> (rd_req && rd_addr == $past(rd_addr) + 32'd4));
  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: no restart straight out of completion
  a_r10_quiet_after: assert property (@(posedge clk) disable iff (rst)
    done |=> !rd_req);
  // R7: bank latched for the whole sequence
  a_r7_bank_stable: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> $stable(bank_q));
endmodule

// File: rtl/xret_frame_fix.sv
module xret_frame_fix
  import xret_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    done,
  input  word_t [FRAME_WORDS-1:0] words,
  input  word_t                   base_q,
  output word_t                   out_r0,
  output word_t                   out_r1,
  output word_t                   out_r2,
  output word_t                   out_r3,
  output word_t                   out_r12,
  output word_t                   out_lr,
  output word_t                   out_pc,
  output word_t                   out_xpsr,
  output logic                    pc_odd,
  output word_t                   sp_new
);
  logic realign;

  assign out_r0   = words[0];
  assign out_r1   = words[1];
  assign out_r2   = words[2];
  assign out_r3   = words[3];
  assign out_r12  = words[4];
  assign out_lr   = words[5];
  assign out_pc   = clean_pc(words[SLOT_PC]);
  assign out_xpsr = strip_psr(words[SLOT_PSR]);
  assign pc_odd   = words[SLOT_PC][0];
  assign realign  = words[SLOT_PSR][REALIGN_BIT];
  assign sp_new   = sp_after(base_q, realign);

  // R6: delivered return address is halfword aligned
  a_r6_pc_even: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_pc[0]);
  // R9: bookkeeping bit never reaches the status output
  a_r9_psr_clean: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_xpsr[REALIGN_BIT]);
  // R8: padding flag forces bit 2 of the new pointer
  a_r8_realign_bit: assert property (@(posedge clk) disable iff (rst)
    (done && realign) |-> sp_new[2]);
endmodule

// File: rtl/xret_unstack.sv
module xret_unstack
  import xret_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] ret_code,
  input  logic        cur_secure,
  input  logic [31:0] cur_sp,
  input  logic [31:0] oth_msp,
  input  logic [31:0] oth_psp,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output logic        done,
  output logic [31:0] out_r0,
  output logic [31:0] out_r1,
  output logic [31:0] out_r2,
  output logic [31:0] out_r3,
  output logic [31:0] out_r12,
  output logic [31:0] out_lr,
  output logic [31:0] out_pc,
  output logic [31:0] out_xpsr,
  output logic        pc_warn,
  output logic        sp_wr_en,
  output logic [1:0]  sp_wr_bank,
  output logic [31:0] sp_wr_val
);
  bank_e                   sel_bank;
  word_t                   sel_base;
  logic                    sel_handler;
  logic                    sel_secure;
  word_t                   base_q;
  bank_e                   bank_q;
  word_t [FRAME_WORDS-1:0] words;
  logic                    ev_accept;
  logic                    ev_capture;
  logic                    ev_last;
  word_t                   sp_new;

  xret_stack_select #(.HAS_SEC(HAS_SEC)) u_sel (
    .ret_code   (ret_code),
    .cur_secure (cur_secure),
    .cur_sp     (cur_sp),
    .oth_msp    (oth_msp),
    .oth_psp    (oth_psp),
    .bank       (sel_bank),
    .frame_base (sel_base),
    .to_handler (sel_handler),
    .to_secure  (sel_secure)
  );

  xret_read_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .frame_base (sel_base),
    .bank_in    (sel_bank),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .done       (done),
    .base_q     (base_q),
    .bank_q     (bank_q),
    .words      (words),
    .ev_accept  (ev_accept),
    .ev_capture (ev_capture),
    .ev_last    (ev_last)
  );

  xret_frame_fix u_fix (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .words    (words),
    .base_q   (base_q),
    .out_r0   (out_r0),
    .out_r1   (out_r1),
    .out_r2   (out_r2),
    .out_r3   (out_r3),
    .out_r12  (out_r12),
    .out_lr   (out_lr),
    .out_pc   (out_pc),
    .out_xpsr (out_xpsr),
    .pc_odd   (pc_warn),
    .sp_new   (sp_new)
  );

  assign sp_wr_en   = done;
  assign sp_wr_bank = bank_q;
  assign sp_wr_val  = sp_new;

  // R11: reset leaves every strobe and flag low
  a_r11_reset_quiet: assert property (@(posedge clk)
    rst |=> (!done && !rd_req && !pc_warn && !sp_wr_en));
  // R3: without the extension a cross-state frame is only taken from a secure core
  a_r3_nosec_target: assert property (@(posedge clk) disable iff (rst)
    (ev_accept && !HAS_SEC) |-> !sel_secure);
  // R2: handler returns never pick the other process stack
  a_r2_handler_main: assert property (@(posedge clk) disable iff (rst)
    (ev_accept && sel_handler) |-> (sel_bank != BANK_OTHER_PROC));
  // R10: a capture that ends the frame leads to completion
  a_r10_last_done: assert property (@(posedge clk) disable iff (rst)
    (ev_capture && ev_last) |=> done);
endmodule

// File: tb/xret_unstack_bench.sv
module xret_unstack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ret_code = '0;
  logic        cur_secure = 1'b0;
  logic [31:0] cur_sp = 32'h2000_1F00;
  logic [31:0] oth_msp = 32'h2000_4A80;
  logic [31:0] oth_psp = 32'h2000_7C40;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        done;
  logic [31:0] out_r0, out_r1, out_r2, out_r3, out_r12, out_lr, out_pc, out_xpsr;
  logic        pc_warn;
  logic        sp_wr_en;
  logic [1:0]  sp_wr_bank;
  logic [31:0] sp_wr_val;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xret_unstack u_xret_unstack (
    .clk(clk), .rst(rst), .start(start), .ret_code(ret_code),
    .cur_secure(cur_secure), .cur_sp(cur_sp), .oth_msp(oth_msp), .oth_psp(oth_psp),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .done(done), .out_r0(out_r0), .out_r1(out_r1), .out_r2(out_r2), .out_r3(out_r3),
    .out_r12(out_r12), .out_lr(out_lr), .out_pc(out_pc), .out_xpsr(out_xpsr),
    .pc_warn(pc_warn), .sp_wr_en(sp_wr_en), .sp_wr_bank(sp_wr_bank), .sp_wr_val(sp_wr_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1357};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog act=%0d exp<%0d", WATCHDOG, WATCHDOG);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // Reference model: one complete return, compared cycle by cycle.
  task automatic run_case(input logic [31:0] code, input logic cs, input int seed,
                          input logic pc_lsb, input logic rlg, input logic poke);
    logic [31:0] fp;
    int          bank;
    logic [31:0] frame[8];
    logic        tsec;
    logic        thread;
    tsec   = code[6];
    thread = (code[3:0] != 4'h1);
    if (tsec == cs) begin bank = 0; fp = cur_sp; end
    else if (thread && code[2]) begin bank = 2; fp = oth_psp; end
    else begin bank = 1; fp = oth_msp; end
    for (int k = 0; k < 8; k++) frame[k] = mem_word(fp + 32'(4*k));
    frame[6] = {frame[6][31:1], pc_lsb};
    frame[7][9] = rlg;

    @(negedge clk);
    ret_code = code; cur_secure = cs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      int d = (seed + 3*k) % 4;
      for (int j = 0; j < d; j++) begin
        rd_ack = 1'b0;
        if (poke && k == 3 && j == 0) start = 1'b1; // R10 ignored while busy
        chk("R4 req", 32'(rd_req), 32'd1);
        chk("R4 addr", rd_addr, fp + 32'(4*k));
        chk("R10 no early done", 32'(done), 32'd0);
        @(negedge clk);
        start = 1'b0;
      end
      rd_ack = 1'b1; rd_data = frame[k];
      chk("R4 req", 32'(rd_req), 32'd1);
      chk(bank == 0 ? "R1 R4 addr" : "R2 R4 addr", rd_addr, fp + 32'(4*k));
      @(negedge clk);
    end
    rd_ack = 1'b0;
    chk("R10 done", 32'(done), 32'd1);
    chk("R5 r0", out_r0, frame[0]);
    chk("R5 r1", out_r1, frame[1]);
    chk("R5 r2", out_r2, frame[2]);
    chk("R5 r3", out_r3, frame[3]);
    chk("R5 r12", out_r12, frame[4]);
    chk("R5 lr", out_lr, frame[5]);
    chk("R6 pc", out_pc, {frame[6][31:1], 1'b0});
    chk("R6 warn", 32'(pc_warn), 32'(pc_lsb));
    chk("R9 xpsr", out_xpsr, frame[7] & ~32'h200);
    chk("R7 wr_en", 32'(sp_wr_en), 32'd1);
    chk(tsec ? "R3 bank" : "R1 R2 bank", 32'(sp_wr_bank), 32'(bank));
    chk(rlg ? "R8 sp" : "R7 sp", sp_wr_val, (fp + 32'h20) | (rlg ? 32'h4 : 32'h0));
    @(negedge clk);
    chk("R10 pulse", 32'(done), 32'd0);
    chk("R7 wr_en off", 32'(sp_wr_en), 32'd0);
    chk("R10 idle", 32'(rd_req), 32'd0);
    if (poke) begin
      @(negedge clk);
      chk("R10 no restart", 32'(rd_req), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 req", 32'(rd_req), 32'd0);
    chk("R11 warn", 32'(pc_warn), 32'd0);
    chk("R11 wr_en", 32'(sp_wr_en), 32'd0);
    rst = 1'b0;

    run_case(32'hFFFF_FFBD, 1'b0, 0, 1'b0, 1'b0, 1'b0); // R1 same state, active
    run_case(32'hFFFF_FFBD, 1'b1, 1, 1'b1, 1'b1, 1'b0); // R2 thread+sel -> other process
    run_case(32'hFFFF_FFB1, 1'b1, 2, 1'b0, 1'b1, 1'b0); // R2 handler -> other main
    run_case(32'hFFFF_FFB9, 1'b1, 3, 1'b1, 1'b0, 1'b0); // R2 thread, sel clear -> other main
    run_case(32'hFFFF_FFFD, 1'b0, 1, 1'b0, 1'b0, 1'b0); // R3 secure target from nonsecure
    run_case(32'hFFFF_FFFD, 1'b1, 2, 1'b1, 1'b1, 1'b1); // R1 R10 same secure, poke start

    // R11: reset in the middle of a sequence
    @(negedge clk);
    ret_code = 32'hFFFF_FFBD; cur_secure = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rd_ack = 1'b1; rd_data = 32'h0000_0001;
    @(negedge clk);
    rd_ack = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 abort req", 32'(rd_req), 32'd0);
    chk("R11 abort done", 32'(done), 32'd0);
    chk("R11 abort warn", 32'(pc_warn), 32'd0);
    run_case(32'hFFFF_FFB9, 1'b0, 0, 1'b1, 1'b1, 1'b0); // R11 recovery

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule